// File: doc/BRIEF.md
# Multi-Lane Receive Deskew Aligner

The block sits behind several parallel receive lanes whose physical paths differ in length. All lanes share one clock derived from a common distributed timebase. Words launched on every transmitter in the same tick reach this block in different cycles. The block measures those differences at run time and removes them. It then holds every lane except the slowest one back, so that time-correlated words leave together at the algorithm interface.

A master pulses `align_cmd`, and every transmitter sends one reserved marker word. Each lane notes the cycle, counted from the command, in which its marker first arrives. When all lanes have reported, each lane is given a delay equal to the latest arrival minus its own arrival. The lane that arrives last therefore passes through with no added register stage. A missing marker or an excessive skew raises an error instead of a lock. The chosen delays and the status flags hold until the next command or reset.

Top module: `dsk_aligner`

## Requirements
- R1: After reset `aligned` and `align_err` are 0 and every lane has zero delay: `out_data`/`out_valid` equal `lane_data`/`lane_valid` in the same cycle.
- R2: A cycle with `align_cmd` high restarts alignment in any state. From the next cycle `aligned` and `align_err` are 0 and all delays are zero until a new result is reached.
- R3: The marker is the 32-bit word 0xBC5A3C7E, and it counts only when the lane's valid bit is high. A lane records the count of its first marker. The count is 0 in the first cycle after the command cycle and rises by one per cycle. A marker in the command cycle, a marker with valid low, and any later repeat are all ignored.
- R4: Lane i occupies bits [32*i+31:32*i] of the data ports and bit i of the valid ports. Once locked, lane i is delayed by (latest recorded count − its own count) cycles, so the latest lane has zero added latency.
- R5: Once locked, words that the transmitters launched in the same tick appear on all lanes of `out_data` in the same cycle.
- R6: Suppose the last missing marker is seen in cycle k. Then `aligned` rises and the new delays take effect in cycle k+2.
- R7: Suppose some lane has no marker by count 31. Then `align_err` rises in the cycle after count 31, `aligned` stays 0 and the delays stay zero. The two flags are never both 1.
- R8: If the spread between latest and earliest counts exceeds 15, `align_err` rises in place of `aligned` and the delays stay zero.
- R9: The lock, or the error, and the delays hold unchanged until the next `align_cmd` or reset.
- R10: Each lane's valid bit is delayed by exactly the same number of cycles as its data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_cmd | input | 1 | Broadcast alignment request, one cycle |
| lane_data | input | LANES*DATA_W | Received words, lane i in slice i |
| lane_valid | input | LANES | Per-lane word valid |
| out_data | output | LANES*DATA_W | Deskewed words |
| out_valid | output | LANES | Deskewed valid flags |
| aligned | output | 1 | Delays computed and applied |
| align_err | output | 1 | Marker missing or skew too large |

## Verification
The bound checker watches the cycle-by-cycle invariants. These are that the flags are mutually exclusive, that a command clears both flags, and that a lock or an error persists while no command arrives. It also checks that outputs equal inputs whenever the block is not locked, and that a locked setting always leaves at least one lane at zero delay. Whether the measured counts are right, whether the delays make the lanes coincide, the exact cycle in which the lock appears, and the timeout and skew limits at their edges can only be shown by the bench scenarios. For those, a behavioural model replays skewed transmit streams with missing, hidden and repeated markers.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MEAS,
      ST_EVAL,
      ST_LOCK,
      ST_FAIL
   } dsk_state_e;

   localparam logic [31:0] DEF_MARKER = 32'hBC5A_3C7E;

endpackage

// File: rtl/dsk_arrival_meas.sv
// Per-lane marker arrival recorder: first marker (valid high) after the
// command latches the running count.
module dsk_arrival_meas #(
   parameter int              LANES  = 4,
   parameter int              DATA_W = 32,
   parameter int              CNT_W  = 5,
   parameter logic [DATA_W-1:0] MARKER = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    measuring,
   input  logic [CNT_W-1:0]        cnt,
   input  logic [LANES*DATA_W-1:0] lane_data,
   input  logic [LANES-1:0]        lane_valid,
   output logic [LANES-1:0]        found_next,
   output logic [LANES*CNT_W-1:0]  arr
);

   logic [LANES-1:0] found_q;
   logic [LANES-1:0] hit;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic             f_q;
      logic [CNT_W-1:0] a_q;

      assign hit[i] = lane_valid[i] && (lane_data[i*DATA_W +: DATA_W] == MARKER);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q <= 1'b0;
            a_q <= '0;
         end else if (clear) begin
            f_q <= 1'b0;
            a_q <= '0;
         end else if (measuring && hit[i] && !f_q) begin
            f_q <= 1'b1;
            a_q <= cnt;
         end
      end

      assign found_q[i]                = f_q;
      assign arr[i*CNT_W +: CNT_W]     = a_q;
   end

   assign found_next = found_q | (hit & {LANES{measuring}});

endmodule

// File: rtl/dsk_delay_calc.sv
// Turns recorded arrival counts into per-lane delays referenced to the
// latest lane, and flags a spread the shift lines cannot cover.
module dsk_delay_calc #(
   parameter int LANES = 4,
   parameter int CNT_W = 5,
   parameter int DLY_W = 4,
   parameter int DEPTH = 16
) (
   input  logic [LANES*CNT_W-1:0] arr,
   output logic [LANES*DLY_W-1:0] dly,
   output logic                   skew_bad
);

   if (LANES == 1) begin : g_single
      logic unused_arr;
      assign unused_arr = ^arr;
      assign dly        = '0;
      assign skew_bad   = 1'b0;
   end else begin : g_multi
      logic [CNT_W-1:0] mx;
      logic [CNT_W-1:0] mn;

      always_comb begin
         mx = arr[0 +: CNT_W];
         mn = arr[0 +: CNT_W];
         for (int i = 1; i < LANES; i++) begin
            if (arr[i*CNT_W +: CNT_W] > mx) mx = arr[i*CNT_W +: CNT_W];
            if (arr[i*CNT_W +: CNT_W] < mn) mn = arr[i*CNT_W +: CNT_W];
         end
         skew_bad = (mx - mn) > CNT_W'(DEPTH - 1);
         for (int i = 0; i < LANES; i++) begin
            dly[i*DLY_W +: DLY_W] = DLY_W'(mx - arr[i*CNT_W +: CNT_W]);
         end
      end
   end

endmodule

// File: rtl/dsk_shift_line.sv
// Selectable-delay line: delay 0 is a direct path, delay d taps the word
// received d cycles earlier.
module dsk_shift_line #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int DLY_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic [DLY_W-1:0]  dly,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid
);

   localparam int ENT_W = DATA_W + 1;
   localparam int TAPS  = DEPTH - 1;

   logic [ENT_W-1:0] tap_q [TAPS];
   logic [ENT_W-1:0] sel;
   logic [DLY_W-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < TAPS; k++) tap_q[k] <= '0;
      end else begin
         tap_q[0] <= {in_valid, in_data};
         for (int k = 1; k < TAPS; k++) tap_q[k] <= tap_q[k-1];
      end
   end

   always_comb begin
      idx = dly - 1'b1;
      if (dly == '0) sel = {in_valid, in_data};
      else           sel = tap_q[idx];
   end

   assign {out_valid, out_data} = sel;

endmodule

// File: rtl/dsk_aligner.sv
module dsk_aligner
   import dsk_pkg::*;
#(
   parameter int                LANES   = 4,
   parameter int                DATA_W  = 32,
   parameter int                DEPTH   = 16,
   parameter int                TIMEOUT = 32,
   parameter logic [DATA_W-1:0] MARKER  = DATA_W'(DEF_MARKER)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    align_cmd,
   input  logic [LANES*DATA_W-1:0] lane_data,
   input  logic [LANES-1:0]        lane_valid,
   output logic [LANES*DATA_W-1:0] out_data,
   output logic [LANES-1:0]        out_valid,
   output logic                    aligned,
   output logic                    align_err
);

   localparam int CNT_W = $clog2(TIMEOUT);
   localparam int DLY_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (TIMEOUT < DEPTH) begin : g_bad_timeout
      $error("TIMEOUT must not be smaller than DEPTH");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   dsk_state_e              state_q;
   logic [CNT_W-1:0]        cnt_q;
   logic [LANES*DLY_W-1:0]  dly_q;
   logic [LANES*DLY_W-1:0]  dly_calc;
   logic                    aligned_q;
   logic                    err_q;
   logic                    skew_bad;
   logic                    measuring;
   logic [LANES-1:0]        found_next;
   logic [LANES*CNT_W-1:0]  arr;

   assign measuring = (state_q == ST_MEAS) && !align_cmd;

   dsk_arrival_meas #(
      .LANES (LANES),
      .DATA_W(DATA_W),
      .CNT_W (CNT_W),
      .MARKER(MARKER)
   ) u_meas (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (align_cmd),
      .measuring (measuring),
      .cnt       (cnt_q),
      .lane_data (lane_data),
      .lane_valid(lane_valid),
      .found_next(found_next),
      .arr       (arr)
   );

   dsk_delay_calc #(
      .LANES(LANES),
      .CNT_W(CNT_W),
      .DLY_W(DLY_W),
      .DEPTH(DEPTH)
   ) u_calc (
      .arr     (arr),
      .dly     (dly_calc),
      .skew_bad(skew_bad)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_line
      dsk_shift_line #(
         .DATA_W(DATA_W),
         .DEPTH (DEPTH),
         .DLY_W (DLY_W)
      ) u_line (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_data  (lane_data[i*DATA_W +: DATA_W]),
         .in_valid (lane_valid[i]),
         .dly      (dly_q[i*DLY_W +: DLY_W]),
         .out_data (out_data[i*DATA_W +: DATA_W]),
         .out_valid(out_valid[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         dly_q     <= '0;
         aligned_q <= 1'b0;
         err_q     <= 1'b0;
      end else if (align_cmd) begin
         state_q   <= ST_MEAS;
         cnt_q     <= '0;
         dly_q     <= '0;
         aligned_q <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_MEAS: begin
               cnt_q <= cnt_q + 1'b1;
               if (&found_next) begin
                  state_q <= ST_EVAL;
               end else if (cnt_q == CNT_W'(TIMEOUT - 1)) begin
                  state_q <= ST_FAIL;
                  err_q   <= 1'b1;
               end
            end
            ST_EVAL: begin
               if (skew_bad) begin
                  state_q <= ST_FAIL;
                  err_q   <= 1'b1;
               end else begin
                  state_q   <= ST_LOCK;
                  dly_q     <= dly_calc;
                  aligned_q <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign aligned   = aligned_q;
   assign align_err = err_q;

endmodule

// File: rtl/dsk_aligner_chk.sv
module dsk_aligner_chk #(
   parameter int LANES  = 4,
   parameter int DATA_W = 32,
   parameter int DLY_W  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    align_cmd,
   input logic [LANES*DATA_W-1:0] lane_data,
   input logic [LANES-1:0]        lane_valid,
   input logic [LANES*DATA_W-1:0] out_data,
   input logic [LANES-1:0]        out_valid,
   input logic                    aligned,
   input logic                    align_err,
   input logic [LANES*DLY_W-1:0]  dly
);

   logic [LANES-1:0] zero_dly;
   for (genvar i = 0; i < LANES; i++) begin : g_z
      assign zero_dly[i] = (dly[i*DLY_W +: DLY_W] == '0);
   end

   p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(aligned && align_err));

   p_cmd_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      align_cmd |=> (!aligned && !align_err));

   p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned && !align_cmd) |=> aligned);

   p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (align_err && !align_cmd) |=> align_err);

   p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !aligned |-> (out_data == lane_data && out_valid == lane_valid));

   p_zero_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      aligned |-> (|zero_dly));

endmodule

bind dsk_aligner dsk_aligner_chk #(
   .LANES (LANES),
   .DATA_W(DATA_W),
   .DLY_W (DLY_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .align_cmd (align_cmd),
   .lane_data (lane_data),
   .lane_valid(lane_valid),
   .out_data  (out_data),
   .out_valid (out_valid),
   .aligned   (aligned),
   .align_err (align_err),
   .dly       (dly_q)
);

// File: tb/tb_dsk_aligner.sv
module tb_dsk_aligner;

   localparam int          PERIOD = 10;
   localparam int          L      = 4;
   localparam int          DW     = 32;
   localparam int          DEP    = 16;
   localparam int          TO     = 32;
   localparam logic [31:0] MK     = 32'hBC5A3C7E;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              align_cmd = 1'b0;
   logic [L*DW-1:0]   lane_data = '0;
   logic [L-1:0]      lane_valid = '0;
   logic [L*DW-1:0]   out_data;
   logic [L-1:0]      out_valid;
   logic              aligned;
   logic              align_err;

   always #(PERIOD/2) clk = ~clk;

   dsk_aligner dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .align_cmd (align_cmd),
      .lane_data (lane_data),
      .lane_valid(lane_valid),
      .out_data  (out_data),
      .out_valid (out_valid),
      .aligned   (aligned),
      .align_err (align_err)
   );

   int vecs = 0;
   int fails = 0;
   bit started = 0;
   bit finished = 0;

   // stimulus state
   int t = 0;
   int skew [L];
   int mk_t = -1000;
   int miss_lane = -1;
   bit fake_en = 0;

   // reference model state
   int   m_st = 0;          // 0 idle 1 meas 2 eval 3 lock 4 fail
   int   m_cnt = 0;
   bit   m_found [L];
   int   m_arr [L];
   int   m_dly [L];
   bit   m_al = 0;
   bit   m_err = 0;
   bit   all_f;
   int   mx, mn;
   logic [32:0] m_hist [L][$];

   function automatic logic [32:0] hist_at(int lane, int idx);
      if (idx < m_hist[lane].size()) return m_hist[lane][idx];
      return '0;
   endfunction

   always @(posedge clk) begin
      started = 1;
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_al = 0; m_err = 0;
         for (int i = 0; i < L; i++) begin
            m_found[i] = 0; m_arr[i] = 0; m_dly[i] = 0;
            m_hist[i].delete();
         end
      end else begin
         for (int i = 0; i < L; i++) begin
            m_hist[i].push_front({lane_valid[i], lane_data[i*DW +: DW]});
            if (m_hist[i].size() > DEP) void'(m_hist[i].pop_back());
         end
         if (align_cmd) begin
            m_st = 1; m_cnt = 0; m_al = 0; m_err = 0;
            for (int i = 0; i < L; i++) begin
               m_found[i] = 0; m_arr[i] = 0; m_dly[i] = 0;
            end
         end else if (m_st == 1) begin
            all_f = 1;
            for (int i = 0; i < L; i++) begin
               if (!m_found[i] && lane_valid[i] && lane_data[i*DW +: DW] == MK) begin
                  m_found[i] = 1; m_arr[i] = m_cnt;
               end
               all_f &= m_found[i];
            end
            if (all_f) m_st = 2;
            else if (m_cnt == TO - 1) begin m_st = 4; m_err = 1; end
            m_cnt++;
         end else if (m_st == 2) begin
            mx = m_arr[0]; mn = m_arr[0];
            for (int i = 1; i < L; i++) begin
               if (m_arr[i] > mx) mx = m_arr[i];
               if (m_arr[i] < mn) mn = m_arr[i];
            end
            if (mx - mn > DEP - 1) begin m_st = 4; m_err = 1; end
            else begin
               for (int i = 0; i < L; i++) m_dly[i] = mx - m_arr[i];
               m_st = 3; m_al = 1;
            end
         end
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (started && !finished) begin
         vecs++;
         if (aligned !== m_al || align_err !== m_err) begin
            fails++;
            $display("FAIL R2 R6 R7 R8 R9 flags: act al=%b err=%b exp al=%b err=%b t=%0d",
                     aligned, align_err, m_al, m_err, t);
         end
         for (int i = 0; i < L; i++) begin
            logic [32:0] e;
            if (m_dly[i] == 0) e = {lane_valid[i], lane_data[i*DW +: DW]};
            else               e = hist_at(i, m_dly[i] - 1);
            if ({out_valid[i], out_data[i*DW +: DW]} !== e) begin
               fails++;
               $display("FAIL R1 R4 R10 lane %0d: act %h exp %h t=%0d",
                        i, {out_valid[i], out_data[i*DW +: DW]}, e, t);
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      vecs++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act %0h exp %0h", tag, act, exp);
      end
   endtask

   task automatic drive();
      for (int i = 0; i < L; i++) begin
         int k;
         k = t - skew[i];
         if (k == mk_t && i != miss_lane) begin
            lane_data[i*DW +: DW] = MK;
            lane_valid[i]         = 1'b1;
         end else if (fake_en && (k == mk_t - 2 || k == mk_t + 4)) begin
            lane_data[i*DW +: DW] = MK;
            lane_valid[i]         = (k == mk_t + 4);  // hidden early, repeat late
         end else begin
            lane_data[i*DW +: DW] = {8'(i), 24'(k)};
            lane_valid[i]         = ((k % 7) != 6);
         end
      end
   endtask

   task automatic step(input bit cmd);
      @(posedge clk);
      #1;
      t++;
      align_cmd = cmd;
      drive();
   endtask

   task automatic check_coincide(input string tag);
      logic [23:0] ref_k;
      ref_k = out_data[23:0];
      for (int i = 1; i < L; i++)
         chk(out_data[i*DW +: 24] == ref_k, tag, 64'(out_data[i*DW +: 24]), 64'(ref_k));
   endtask

   task automatic do_align(input int s0, input int s1, input int s2, input int s3,
                           input int miss, input bit fake, input bit ok, input string tag);
      int latest;
      skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
      miss_lane = miss; fake_en = fake;
      repeat (20) step(0);
      mk_t = t + 3;
      step(1);
      step(0);
      @(negedge clk);
      chk(!aligned && !align_err, "R2 flags cleared after command", {62'd0, aligned, align_err}, 64'd0);
      repeat (45) step(0);
      @(negedge clk);
      chk(aligned == ok, {tag, " aligned"}, 64'(aligned), 64'(ok));
      chk(align_err == !ok, {tag, " align_err"}, 64'(align_err), 64'(!ok));
      if (ok) begin
         check_coincide("R5 coincident launch tick");
         latest = 0;
         for (int i = 1; i < L; i++) if (skew[i] > skew[latest]) latest = i;
         chk(out_data[latest*DW +: DW] == lane_data[latest*DW +: DW],
             "R4 latest lane zero added latency",
             64'(out_data[latest*DW +: DW]), 64'(lane_data[latest*DW +: DW]));
      end
   endtask

   initial begin
      for (int i = 0; i < L; i++) skew[i] = i;
      repeat (3) step(0);
      rst_n = 1'b1;
      step(0);
      @(negedge clk);
      chk(!aligned && !align_err, "R1 reset flags", {62'd0, aligned, align_err}, 64'd0);
      chk(out_data == lane_data && out_valid == lane_valid, "R1 reset passthrough",
          64'(out_data[31:0]), 64'(lane_data[31:0]));

      do_align(0, 3, 7, 2, -1, 0, 1, "R4 R6 mixed skew");
      repeat (40) step(0);
      @(negedge clk);
      chk(aligned, "R9 lock held", 64'(aligned), 64'd1);
      check_coincide("R5 R9 still coincident");

      do_align(5, 5, 5, 5, -1, 0, 1, "R4 equal skew");
      do_align(0, 15, 4, 9, -1, 1, 1, "R3 R8 skew 15 hidden and repeated markers");
      do_align(0, 16, 1, 1, -1, 0, 0, "R8 skew 16");
      repeat (30) step(0);
      @(negedge clk);
      chk(align_err && !aligned, "R9 error held", {62'd0, aligned, align_err}, 64'd1);
      do_align(2, 0, 6, 1, 2, 0, 0, "R7 missing marker");
      do_align(9, 2, 0, 4, -1, 1, 1, "R2 realign after error");

      rst_n = 1'b0;
      step(0);
      step(0);
      @(negedge clk);
      chk(!aligned && !align_err, "R1 mid reset flags", {62'd0, aligned, align_err}, 64'd0);
      rst_n = 1'b1;
      step(0);
      @(negedge clk);
      chk(out_data == lane_data, "R1 delays cleared by reset",
          64'(out_data[63:32]), 64'(lane_data[63:32]));

      repeat (5) step(0);
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin
      #(PERIOD * 100000);
      if (!finished) begin
         finished = 1;
         fails++;
         $display("FAIL watchdog expired: act running exp finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
         $finish;
      end
   end

endmodule